// File: doc/BRIEF.md
# Fuse Block Access Engine

This engine sits between a register bus and a one-time-programmable fuse array organised as 16-byte blocks. Software loads four 32-bit data registers and one control word. The control word holds a block address, an access mode and a start bit. The engine then runs one of three transfers. It can fetch a physical block into the data registers. It can program a physical block from the data registers. It can look up a logical block through an on-array translation table and then fetch the physical block that the table names. The start bit clears itself when the transfer finishes, so software polls it.

The array is split in two. The last `MAP_BLKS` blocks hold the translation table, one byte per data block: the table byte for physical block p is byte p mod 16 of table block `DATA_BLKS + p/16`. A table byte whose bits 7:6 are `01` and whose bits 5:0 equal a logical block number maps that logical block to p. Fuses only change from 0 to 1, so an entry is retired by setting bit 7, which makes its tag `11`. Each array access waits `LAT` cycles before its result is used.

Top module: `fuse_blk_engine`

## Requirements
- R1: After reset the control word (bus word 0), all four data registers (bus words 4 to 7) and `fa_req` are zero.
- R2: The control word carries the 10-bit address in bits 25:16, the mode in bits 7:6, the start bit in bit 30 and the 6-bit result in bits 13:8. Address and mode read back as written. The block number is address bits 9:4, and the low four address bits have no effect on which block is used.
- R3: Mode 1 (physical read) loads block `addr[9:4]` into the data registers. Block byte b lands in bus word `7 - b/4`, at bit position `8*(b mod 4)`, so word 7 holds bytes 3..0 and word 4 holds bytes 15..12.
- R4: Mode 3 (physical write) issues one array write to block `addr[9:4]`, carrying all 16 bytes in the same byte order as R3. The array ORs those bytes into its stored bits.
- R5: Mode 0 (logical read) searches the table entries of data blocks 0 to `DATA_BLKS-1` in ascending order. It takes the lowest p whose entry is `{2'b01, addr[9:4]}`, reports p in the result field and loads block p as in R3. Entry bytes beyond `DATA_BLKS-1` never match.
- R6: If a logical read finds no matching entry, the result field is 0x3f and all four data registers read 0xFFFFFFFF.
- R7: An entry whose tag bits 7:6 are not `01` never matches, so a later valid entry for the same logical block is used instead.
- R8: The start bit clears by itself when the operation ends. It is never set for more than `1 + (MAP_BLKS+1)*(LAT+1)` consecutive cycles.
- R9: While the start bit is set, bus writes to the control word and to the data registers have no effect.
- R10: Mode 2 is reserved. Starting it clears the start bit without any array access, and it leaves the result field and the data registers unchanged.
- R11: A control write with bit 30 at zero updates address and mode only. It starts no array access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Bus write strobe |
| reg_addr | input | 3 | Bus word index: 0 control, 4..7 data |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Bus read data for `reg_addr`, combinational |
| fa_req | output | 1 | Array access request, one cycle per access |
| fa_we | output | 1 | Access is a program operation |
| fa_blk | output | 6 | Physical block index, held through the access |
| fa_wdata | output | 128 | Block image to program, byte b at bits 8b+7:8b |
| fa_rdata | input | 128 | Block image read from `fa_blk` |

## Verification
Each internal fault has a distinct signature at the ports. A wrong table-scan step or a wrong priority shows up as a wrong result field within one operation: the wrong block number, or a spurious 0x3f. A wrong byte lane shows up as a misplaced byte in one of the four data words on the next read-back. A sequencer that fails to finish leaves the start bit set past its cycle bound, so the very next poll exposes it. A sequencer that accepts bus writes while busy corrupts the address or the data words, and that is visible as soon as the operation ends.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
   localparam int ADDR_W    = 10;
   localparam int LBLK_W    = 6;
   localparam int RES_W     = 6;
   localparam int WORD_W    = 32;
   localparam int WORDS     = 4;
   localparam int BLK_BYTES = 16;
   localparam int BLK_BITS  = WORD_W * WORDS;
   localparam int KICK_BIT  = 30;
   localparam int ADDR_LSB  = 16;
   localparam int RES_LSB   = 8;
   localparam int MODE_LSB  = 6;
   localparam logic [RES_W-1:0] NO_BLOCK  = 6'h3f;
   localparam logic [1:0]       LIVE_TAG  = 2'b01;

   typedef enum logic [1:0] {
      MD_LOGICAL = 2'd0,
      MD_PHYS_RD = 2'd1,
      MD_RESV    = 2'd2,
      MD_PHYS_WR = 2'd3
   } acc_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_REQ,
      ST_WAIT
   } seq_st_e;

   typedef enum logic [1:0] {
      PH_SCAN,
      PH_FETCH,
      PH_PROG
   } seq_ph_e;
endpackage

// File: rtl/fuse_wait_timer.sv
module fuse_wait_timer #(
   parameter int LAT = 3,
   localparam int CW = (LAT > 1) ? $clog2(LAT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic done_o
);
   if (LAT < 1) begin : g_bad_lat
      $error("fuse_wait_timer: LAT must be at least 1");
   end

   logic          running;
   logic [CW-1:0] cnt;
   logic          at_end;

   assign at_end = (cnt == CW'(LAT - 1));
   assign done_o = running && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (start_i) begin
         running <= 1'b1;
         cnt     <= '0;
      end else if (running) begin
         if (at_end) running <= 1'b0;
         else        cnt     <= cnt + 1'b1;
      end
   end

   // R8
   timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o || start_i);
endmodule

// File: rtl/fuse_map_match.sv
module fuse_map_match
   import fuse_pkg::*;
#(
   parameter int ENTRIES = 16,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic [8*ENTRIES-1:0] entries_i,
   input  logic [ENTRIES-1:0]   allow_i,
   input  logic [LBLK_W-1:0]    key_i,
   output logic                 hit_o,
   output logic [IDX_W-1:0]     idx_o
);
   logic [ENTRIES-1:0] eq;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign eq[e] = allow_i[e]
                   && (entries_i[8*e+6 +: 2] == LIVE_TAG)
                   && (entries_i[8*e +: LBLK_W] == key_i);
   end

   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (eq[e]) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(e);
         end
      end
   end

   // R7
   always_comb begin
      if (hit_o) begin
         tag_live_chk: assert (entries_i[8*idx_o+6 +: 2] == LIVE_TAG);
      end
   end
endmodule

// File: rtl/fuse_blk_engine.sv
module fuse_blk_engine
   import fuse_pkg::*;
#(
   parameter int MAP_BLKS = 4,
   parameter int LAT      = 3,
   localparam int BLK_W     = ADDR_W - 4,
   localparam int NUM_BLK   = 2 ** BLK_W,
   localparam int DATA_BLKS = NUM_BLK - MAP_BLKS,
   localparam int MI_W      = (MAP_BLKS > 1) ? $clog2(MAP_BLKS) : 1,
   localparam int EIDX_W    = $clog2(BLK_BYTES),
   localparam int BUSY_MAX  = 1 + (MAP_BLKS + 1) * (LAT + 1),
   localparam int BC_W      = $clog2(BUSY_MAX + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [2:0]           reg_addr,
   input  logic [WORD_W-1:0]    reg_wdata,
   output logic [WORD_W-1:0]    reg_rdata,
   output logic                 fa_req,
   output logic                 fa_we,
   output logic [BLK_W-1:0]     fa_blk,
   output logic [BLK_BITS-1:0]  fa_wdata,
   input  logic [BLK_BITS-1:0]  fa_rdata
);
   if (MAP_BLKS < 1 || DATA_BLKS > BLK_BYTES * MAP_BLKS) begin : g_bad_map
      $error("fuse_blk_engine: table region cannot cover the data blocks");
   end
   if (DATA_BLKS > int'(NO_BLOCK)) begin : g_bad_res
      $error("fuse_blk_engine: data blocks collide with the miss code");
   end

   logic [ADDR_W-1:0]             addr_q;
   acc_mode_e                     mode_q;
   logic                          kick_q;
   logic [RES_W-1:0]              res_q;
   logic [WORDS-1:0][WORD_W-1:0]  dreg;
   seq_st_e                       st;
   seq_ph_e                       ph;
   logic [MI_W-1:0]               map_idx;
   logic [BLK_W-1:0]              cur_blk;
   logic                          tmr_done;
   logic                          hit;
   logic [EIDX_W-1:0]             hit_idx;
   logic [BLK_BYTES-1:0]          allow;
   logic [BLK_W-1:0]              hit_blk;
   logic                          unused_wbits;

   assign unused_wbits = ^{reg_wdata[31], reg_wdata[29:26], reg_wdata[15:8], reg_wdata[5:0]};

   assign fa_req   = (st == ST_REQ);
   assign fa_we    = (ph == PH_PROG);
   assign fa_blk   = cur_blk;
   assign fa_wdata = {dreg[0], dreg[1], dreg[2], dreg[3]};

   for (genvar e = 0; e < BLK_BYTES; e++) begin : g_allow
      assign allow[e] = (int'(map_idx) * BLK_BYTES + e) < DATA_BLKS;
   end

   fuse_map_match #(.ENTRIES(BLK_BYTES)) u_match (
      .entries_i (fa_rdata),
      .allow_i   (allow),
      .key_i     (addr_q[ADDR_W-1 -: LBLK_W]),
      .hit_o     (hit),
      .idx_o     (hit_idx)
   );

   fuse_wait_timer #(.LAT(LAT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (st == ST_REQ),
      .done_o  (tmr_done)
   );

   assign hit_blk = (BLK_W'(map_idx) << EIDX_W) | BLK_W'(hit_idx);

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == 3'd0) begin
         reg_rdata[KICK_BIT]              = kick_q;
         reg_rdata[ADDR_LSB +: ADDR_W]    = addr_q;
         reg_rdata[RES_LSB +: RES_W]      = res_q;
         reg_rdata[MODE_LSB +: 2]         = mode_q;
      end else if (reg_addr[2]) begin
         reg_rdata = dreg[reg_addr[1:0]];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         mode_q  <= MD_LOGICAL;
         kick_q  <= 1'b0;
         res_q   <= '0;
         dreg    <= '0;
         st      <= ST_IDLE;
         ph      <= PH_SCAN;
         map_idx <= '0;
         cur_blk <= '0;
      end else begin
         if (reg_we && !kick_q) begin
            if (reg_addr == 3'd0) begin
               addr_q <= reg_wdata[ADDR_LSB +: ADDR_W];
               mode_q <= acc_mode_e'(reg_wdata[MODE_LSB +: 2]);
               kick_q <= reg_wdata[KICK_BIT];
            end else if (reg_addr[2]) begin
               dreg[reg_addr[1:0]] <= reg_wdata;
            end
         end
         unique case (st)
            ST_IDLE: if (kick_q) begin
               unique case (mode_q)
                  MD_LOGICAL: begin
                     ph      <= PH_SCAN;
                     map_idx <= '0;
                     cur_blk <= BLK_W'(DATA_BLKS);
                     st      <= ST_REQ;
                  end
                  MD_PHYS_RD: begin
                     ph      <= PH_FETCH;
                     cur_blk <= addr_q[ADDR_W-1 -: BLK_W];
                     st      <= ST_REQ;
                  end
                  MD_PHYS_WR: begin
                     ph      <= PH_PROG;
                     cur_blk <= addr_q[ADDR_W-1 -: BLK_W];
                     st      <= ST_REQ;
                  end
                  default: kick_q <= 1'b0;
               endcase
            end
            ST_REQ: st <= ST_WAIT;
            ST_WAIT: if (tmr_done) begin
               unique case (ph)
                  PH_SCAN: begin
                     if (hit) begin
                        res_q   <= RES_W'(hit_blk);
                        cur_blk <= hit_blk;
                        ph      <= PH_FETCH;
                        st      <= ST_REQ;
                     end else if (map_idx == MI_W'(MAP_BLKS - 1)) begin
                        res_q  <= NO_BLOCK;
                        dreg   <= '1;
                        kick_q <= 1'b0;
                        st     <= ST_IDLE;
                     end else begin
                        map_idx <= map_idx + 1'b1;
                        cur_blk <= cur_blk + 1'b1;
                        st      <= ST_REQ;
                     end
                  end
                  PH_FETCH: begin
                     for (int k = 0; k < WORDS; k++)
                        dreg[k] <= fa_rdata[(WORDS-1-k)*WORD_W +: WORD_W];
                     kick_q <= 1'b0;
                     st     <= ST_IDLE;
                  end
                  default: begin
                     kick_q <= 1'b0;
                     st     <= ST_IDLE;
                  end
               endcase
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   logic [BC_W-1:0] busy_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_cnt <= '0;
      else if (kick_q) busy_cnt <= busy_cnt + 1'b1;
      else             busy_cnt <= '0;
   end

   // R8
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= BC_W'(BUSY_MAX));

   // R9
   ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kick_q && $past(kick_q)) |-> ($stable(addr_q) && $stable(mode_q)));

   // R10
   idle_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !kick_q |-> !fa_req);

   // R4
   prog_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fa_req && fa_we) |-> (mode_q == MD_PHYS_WR && fa_blk == addr_q[ADDR_W-1 -: BLK_W]));

   // R6
   miss_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(kick_q) && mode_q == MD_LOGICAL && res_q == NO_BLOCK) |-> (dreg == '1));
endmodule

// File: tb/fuse_blk_engine_test.sv
module fuse_blk_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int MAPB = 4;
   localparam int LATC = 3;
   localparam int DBLK = 64 - MAPB;
   localparam int BOUND = 1 + (MAPB + 1) * (LATC + 1);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [2:0]   reg_addr = 3'd0;
   logic [31:0]  reg_wdata = 32'd0;
   logic [31:0]  reg_rdata;
   logic         fa_req, fa_we;
   logic [5:0]   fa_blk;
   logic [127:0] fa_wdata, fa_rdata;

   logic [127:0] mem [64];
   logic [7:0]   ent [64];
   int           nchk = 0;
   int           nfail = 0;
   int           req_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fuse_blk_engine #(.MAP_BLKS(MAPB), .LAT(LATC)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fa_req(fa_req),
      .fa_we(fa_we), .fa_blk(fa_blk), .fa_wdata(fa_wdata), .fa_rdata(fa_rdata));

   assign fa_rdata = mem[fa_blk];
   always @(posedge clk) begin
      if (fa_req) req_cnt <= req_cnt + 1;
      if (fa_req && fa_we) mem[fa_blk] <= mem[fa_blk] | fa_wdata;
   end

   function automatic logic [7:0] pbyte(int p, int b);
      return 8'((p * 37 + b * 11 + 5) % 256);
   endfunction

   function automatic logic [127:0] pblock(int p);
      logic [127:0] v = '0;
      for (int b = 0; b < 16; b++) v[8*b +: 8] = pbyte(p, b);
      return v;
   endfunction

   // bus word w (4..7) holds block bytes 4*(7-w)+3 .. 4*(7-w)
   function automatic logic [31:0] word_of(logic [127:0] blk, int w);
      logic [31:0] v = '0;
      for (int j = 0; j < 4; j++) v[8*j +: 8] = blk[8*(4*(7-w)+j) +: 8];
      return v;
   endfunction

   function automatic logic [31:0] ctl(bit kick, int addr, int mode);
      return (32'(kick) << 30) | (32'(addr & 10'h3ff) << 16) | (32'(mode & 3) << 6);
   endfunction

   function automatic int find_map(int l);
      for (int p = 0; p < DBLK; p++)
         if (ent[p] == {2'b01, 6'(l)}) return p;
      return 63;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_done(output int cyc);
      logic [31:0] v;
      cyc = 0;
      forever begin
         rd(3'd0, v);
         if (!v[30]) break;
         @(negedge clk);
         cyc++;
         if (cyc > 500) begin
            chk("R8 start bit stuck", v, v & ~32'h4000_0000);
            break;
         end
      end
   endtask

   logic [31:0] v;
   logic [31:0] dw [4];
   logic [127:0] wblk;
   int cyc, r0;

   initial begin
      for (int p = 0; p < 64; p++) begin
         ent[p] = 8'h00;
         mem[p] = (p < DBLK) ? pblock(p) : '0;
      end
      ent[12] = 8'h45;              // logical 5
      ent[3]  = 8'hC9;              // logical 9, retired
      ent[40] = 8'h49;              // logical 9
      ent[20] = 8'h47;              // logical 7
      ent[33] = 8'h47;              // logical 7, later duplicate
      ent[50] = 8'h4C;              // logical 12
      ent[59] = 8'h7F;              // logical 63, last data entry
      ent[61] = 8'h72;              // logical 50, beyond data blocks
      for (int p = 0; p < 64; p++)
         mem[DBLK + p/16][8*(p%16) +: 8] = ent[p];

      repeat (3) @(negedge clk);
      // R1 reset state
      rd(3'd0, v); chk("R1 control", v, 32'h0);
      for (int w = 4; w < 8; w++) begin rd(3'(w), v); chk("R1 data", v, 32'h0); end
      chk("R1 fa_req", 32'(fa_req), 32'h0);
      rst_n = 1'b1;

      // R2 / R11 field write without start
      r0 = req_cnt;
      wr(3'd0, ctl(0, 10'h2A5, 1));
      repeat (4) @(negedge clk);
      rd(3'd0, v); chk("R2 R11 control readback", v, ctl(0, 10'h2A5, 1));
      chk("R11 no access", 32'(req_cnt - r0), 32'h0);

      // R3 physical read sweep, junk in low address bits (R2)
      for (int p = 0; p < DBLK; p++) begin
         wr(3'd0, ctl(1, (p << 4) | (p & 15), 1));
         wait_done(cyc);
         for (int w = 4; w < 8; w++) begin
            rd(3'(w), v); chk("R3 physical read word", v, word_of(pblock(p), w));
         end
      end

      // R4 physical write ORs into block 10, R9 writes while busy ignored
      dw[0] = 32'hA5A5_0F0F; dw[1] = 32'h1234_8001;
      dw[2] = 32'h00FF_00FF; dw[3] = 32'hC003_3C30;
      for (int k = 0; k < 4; k++) wr(3'(4 + k), dw[k]);
      wblk = {dw[0], dw[1], dw[2], dw[3]};
      wr(3'd0, ctl(1, 10 << 4, 3));
      wr(3'd0, ctl(0, 10'h155, 1));
      wr(3'd4, 32'hDEAD_BEEF);
      wait_done(cyc);
      rd(3'd0, v); chk("R9 control kept", v & 32'h03FF_00C0, ctl(0, 10 << 4, 3));
      rd(3'd4, v); chk("R9 data kept", v, dw[0]);
      wr(3'd0, ctl(1, 10 << 4, 1));
      wait_done(cyc);
      for (int w = 4; w < 8; w++) begin
         rd(3'(w), v); chk("R4 programmed block", v, word_of(pblock(10) | wblk, w));
      end

      // R5 R6 R7 logical sweep
      for (int l = 0; l < 64; l++) begin
         int p;
         p = find_map(l);
         wr(3'd0, ctl(1, (l << 4) | 7, 0));
         wait_done(cyc);
         chk("R8 bound", 32'(cyc <= BOUND), 32'h1);
         rd(3'd0, v); chk("R5 R6 result field", 32'(v[13:8]), 32'(p));
         for (int w = 4; w < 8; w++) begin
            rd(3'(w), v);
            if (p == 63) chk("R6 miss data", v, 32'hFFFF_FFFF);
            else         chk("R5 R7 mapped data", v, word_of(pblock(p), w));
         end
      end
      chk("R7 retired entry skipped", 32'(find_map(9)), 32'd40);

      // R10 reserved mode
      for (int k = 0; k < 4; k++) wr(3'(4 + k), 32'h5A00_0000 + 32'(k));
      r0 = req_cnt;
      wr(3'd0, ctl(1, 10'h3C0, 2));
      wait_done(cyc);
      repeat (2) @(negedge clk);
      rd(3'd0, v);
      chk("R10 start cleared", 32'(v[30]), 32'h0);
      chk("R10 result kept", 32'(v[13:8]), 32'd59);
      chk("R10 no access", 32'(req_cnt - r0), 32'h0);
      for (int k = 0; k < 4; k++) begin
         rd(3'(4 + k), v); chk("R10 data kept", v, 32'h5A00_0000 + 32'(k));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      nchk++; nfail++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule